// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block merges the interrupt causes of a 16550-style serial controller into one interrupt line and an identification byte that the host reads to find the cause. It takes five sources: receiver line errors, received data (data ready in character mode, trigger level reached in FIFO mode), character timeout, transmit holding register empty, and modem-status change. It gates each source with its enable bit and reports the most urgent pending one.

Line-error and modem-change events arrive as one-cycle pulses and are held in sticky flags. Those flags clear when the host reads the line status or modem status register. The holding-empty condition is also held as a flag. It clears when the holding register is written, or when the identification register is read while that flag is the cause being reported. Received data, trigger and timeout are level inputs that the receive datapath owns. The identification byte and the interrupt line are combinational from the flags and the current inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset all held flags are clear, `iir_o` reads 8'h01 and `irq_o` is low.
- R2: `iir_o[0]` is 0 exactly when some enabled source is pending, and `irq_o` is high exactly then.
- R3: Enable bit positions in `ier_en_i` are: bit 0 received data, bit 1 holding empty, bit 2 line status, bit 3 modem status. A source whose bit is 0 neither raises `irq_o` nor appears in the code.
- R4: Priority order, highest first, with the code in `iir_o[3:1]`: line status 011, received data 010, timeout 110, holding empty 001, modem status 000.
- R5: The received-data source is `rx_trig_i` in FIFO mode and `rx_ready_i` in character mode. It is a level and takes effect in the same cycle.
- R6: Timeout (`rx_timeout_i`) is reported only when `fifo_mode_i` is 1. In character mode it is ignored and `iir_o[3]` stays 0.
- R7: `iir_o[7:6]` are both 1 in FIFO mode and both 0 in character mode. `iir_o[5:4]` are always 0.
- R8: Any bit of `line_err_i` (overrun, parity, framing, break) sets the line flag, which is seen from the next cycle. A `rd_lsr_i` strobe clears it.
- R9: Any bit of `mdm_delta_i` (CTS change, DSR change, ring trailing edge, DCD change) sets the modem flag, which is seen from the next cycle. A `rd_msr_i` strobe clears it.
- R10: The holding-empty flag is set in any cycle where `thr_empty_i` and `ier_en_i[1]` are both 1 but were not both 1 in the cycle before. It is cleared by `wr_thr_i`, or by `rd_iir_i` in a cycle where `iir_o[3:0]` reads 4'b0010.
- R11: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_en_i | input | 4 | Source enables (see R3) |
| fifo_mode_i | input | 1 | 1 = FIFO mode, 0 = character mode |
| rx_ready_i | input | 1 | Receive data present (character mode) |
| rx_trig_i | input | 1 | Receive FIFO at or above trigger level |
| rx_timeout_i | input | 1 | Character timeout condition |
| thr_empty_i | input | 1 | Transmit holding register / FIFO empty |
| line_err_i | input | 4 | Line error event pulses |
| mdm_delta_i | input | 4 | Modem status change pulses |
| rd_iir_i | input | 1 | Host read of identification register |
| rd_lsr_i | input | 1 | Host read of line status register |
| rd_msr_i | input | 1 | Host read of modem status register |
| wr_thr_i | input | 1 | Host write of holding register |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can fall in the same cycle: a new event setting a flag, and a host access clearing that same flag. This happens for an error pulse with a line-status read, a modem pulse with a modem-status read, and a holding-empty re-arm with a holding-register write. Directed steps place each pair in one cycle, and random stimulus hits them often through biased strobe rates. The bench judges every cycle against its own flag model, in which a set wins. It also checks the clear-on-identification-read, which depends on the code reported in that same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_SRC = 5;
  // source slots in priority order, index 0 highest
  localparam int S_LINE = 0;
  localparam int S_DATA = 1;
  localparam int S_TMO  = 2;
  localparam int S_THRE = 3;
  localparam int S_MDM  = 4;

  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  function automatic irq_id_e pick_id(input logic [N_SRC-1:0] act);
    if (act[S_LINE])      return ID_LINE;
    else if (act[S_DATA]) return ID_RXDATA;
    else if (act[S_TMO])  return ID_TIMEOUT;
    else if (act[S_THRE]) return ID_THRE;
    else                  return ID_MODEM;
  endfunction

  function automatic logic [7:0] build_iir(input logic any, input irq_id_e id,
                                           input logic fifo);
    return {fifo, fifo, 2'b00, id, ~any};
  endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic         pend_o
);
  logic set_any;
  assign set_any = |set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (set_any) pend_o <= 1'b1;
    else if (clr_i)   pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic en_i,
  input  logic clr_i,
  output logic set_o,
  output logic pend_o
);
  logic armed_now, armed_q;
  assign armed_now = empty_i & en_i;
  assign set_o     = armed_now & ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_now;
  end

  uart_irq_sticky #(.W(1)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set_o), .clr_i(clr_i), .pend_o(pend_o)
  );
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [N_SRC-1:0] act_i,
  input  logic             fifo_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  irq_id_e id;
  logic    any;
  always_comb begin
    any   = |act_i;
    id    = pick_id(act_i);
    iir_o = build_iir(any, id, fifo_i);
    irq_o = any;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 4,
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_en_i,
  input  logic             fifo_mode_i,
  input  logic             rx_ready_i,
  input  logic             rx_trig_i,
  input  logic             rx_timeout_i,
  input  logic             thr_empty_i,
  input  logic [ERR_W-1:0] line_err_i,
  input  logic [MDM_W-1:0] mdm_delta_i,
  input  logic             rd_iir_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             wr_thr_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  localparam logic [3:0] THRE_NIBBLE = {ID_THRE, 1'b0};

  logic             line_pend, mdm_pend, thre_pend, thre_set, thre_clr;
  logic             data_src;
  logic [N_SRC-1:0] act;

  uart_irq_sticky #(.W(ERR_W)) u_line (
    .clk(clk), .rst_n(rst_n), .set_i(line_err_i), .clr_i(rd_lsr_i), .pend_o(line_pend)
  );

  uart_irq_sticky #(.W(MDM_W)) u_mdm (
    .clk(clk), .rst_n(rst_n), .set_i(mdm_delta_i), .clr_i(rd_msr_i), .pend_o(mdm_pend)
  );

  assign thre_clr = wr_thr_i | (rd_iir_i & (iir_o[3:0] == THRE_NIBBLE));

  uart_irq_thre u_thre (
    .clk(clk), .rst_n(rst_n), .empty_i(thr_empty_i), .en_i(ier_en_i[1]),
    .clr_i(thre_clr), .set_o(thre_set), .pend_o(thre_pend)
  );

  assign data_src = fifo_mode_i ? rx_trig_i : rx_ready_i;

  always_comb begin
    act         = '0;
    act[S_LINE] = line_pend & ier_en_i[2];
    act[S_DATA] = data_src  & ier_en_i[0];
    act[S_TMO]  = rx_timeout_i & fifo_mode_i & ier_en_i[0];
    act[S_THRE] = thre_pend & ier_en_i[1];
    act[S_MDM]  = mdm_pend  & ier_en_i[3];
  end

  uart_irq_prio u_prio (
    .act_i(act), .fifo_i(fifo_mode_i), .iir_o(iir_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int ERR_W = 4,
  parameter int MDM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ier_en_i,
  input logic             fifo_mode_i,
  input logic [ERR_W-1:0] line_err_i,
  input logic [MDM_W-1:0] mdm_delta_i,
  input logic             rd_lsr_i,
  input logic             rd_msr_i,
  input logic             wr_thr_i,
  input logic             line_pend,
  input logic             mdm_pend,
  input logic             thre_pend,
  input logic             thre_set,
  input logic [7:0]       iir_o,
  input logic             irq_o
);
  // R2
  irq_pending_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !iir_o[0]);
  // R7
  char_mode_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode_i |-> (iir_o[7:6] == 2'b00 && !iir_o[3]));
  // R7
  mid_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[5:4] == 2'b00);
  // R4
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pend && ier_en_i[2]) |-> iir_o[3:0] == 4'b0110);
  // R8
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_i && line_err_i == '0) |=> !line_pend);
  // R9
  msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr_i && mdm_delta_i == '0) |=> !mdm_pend);
  // R10
  thr_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr_i && !thre_set) |=> !thre_pend);
  // R11
  line_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err_i != '0) |=> line_pend);
  // R11
  mdm_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_delta_i != '0) |=> mdm_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ERR_W(ERR_W), .MDM_W(MDM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ier_en_i(ier_en_i), .fifo_mode_i(fifo_mode_i),
  .line_err_i(line_err_i), .mdm_delta_i(mdm_delta_i), .rd_lsr_i(rd_lsr_i),
  .rd_msr_i(rd_msr_i), .wr_thr_i(wr_thr_i), .line_pend(line_pend),
  .mdm_pend(mdm_pend), .thre_pend(thre_pend), .thre_set(thre_set),
  .iir_o(iir_o), .irq_o(irq_o)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] en = '0;
  logic       fifo = 0, rdy = 0, trig = 0, tmo = 0, thr = 0;
  logic [3:0] err = '0, dlt = '0;
  logic       r_iir = 0, r_lsr = 0, r_msr = 0, w_thr = 0;
  logic [7:0] iir;
  logic       irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  // bench model of held flags
  bit m_line = 0, m_mdm = 0, m_thre = 0, m_arm = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .ier_en_i(en), .fifo_mode_i(fifo),
    .rx_ready_i(rdy), .rx_trig_i(trig), .rx_timeout_i(tmo), .thr_empty_i(thr),
    .line_err_i(err), .mdm_delta_i(dlt), .rd_iir_i(r_iir), .rd_lsr_i(r_lsr),
    .rd_msr_i(r_msr), .wr_thr_i(w_thr), .iir_o(iir), .irq_o(irq)
  );

  function automatic logic [7:0] exp_iir();
    logic [2:0] c;
    logic pend;
    logic dsrc;
    dsrc = fifo ? trig : rdy;
    pend = 1'b1; c = 3'b000;
    if (m_line && en[2])             c = 3'b011;
    else if (dsrc && en[0])          c = 3'b010;
    else if (fifo && tmo && en[0])   c = 3'b110;
    else if (m_thre && en[1])        c = 3'b001;
    else if (m_mdm && en[3])         c = 3'b000;
    else                             pend = 1'b0;
    return {fifo, fifo, 2'b00, c, !pend};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // checks outputs at negedge, then advances the model across the next edge
  task automatic step(string req);
    logic [7:0] e;
    bit arm_now, tset, nl, nm, nt;
    @(negedge clk);
    e = exp_iir();
    check(req, iir, e);
    check(req, {7'd0, irq}, {7'd0, !e[0]});
    arm_now = thr && en[1];
    tset    = arm_now && !m_arm;
    nl = (err != 0) ? 1 : (r_lsr ? 0 : m_line);
    nm = (dlt != 0) ? 1 : (r_msr ? 0 : m_mdm);
    nt = tset ? 1 : ((w_thr || (r_iir && e[3:0] == 4'b0010)) ? 0 : m_thre);
    @(posedge clk);
    m_line = nl; m_mdm = nm; m_thre = nt; m_arm = arm_now;
    #1;
    err = '0; dlt = '0; r_iir = 0; r_lsr = 0; r_msr = 0; w_thr = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1", iir, 8'h01);
    check("R1", {7'd0, irq}, 8'h00);
    @(posedge clk); #1;

    // R8 / R4: error pulse, seen next cycle, beats data ready
    en = 4'hF; rdy = 1; err = 4'b0100;
    step("R4");
    step("R8");                         // expect 0x06
    r_lsr = 1; step("R8");              // clears -> data 0x04 afterwards
    step("R5");
    // R11 pulse and read in the same cycle
    err = 4'b0001; r_lsr = 1; step("R11");
    step("R11");
    r_lsr = 1; step("R8");
    rdy = 0;
    // R9 modem
    dlt = 4'b1000; step("R9");
    step("R9");
    dlt = 4'b0010; r_msr = 1; step("R11");
    r_msr = 1; step("R9");
    step("R9");
    // R10 holding empty, cleared by identification read
    thr = 1; step("R10");
    step("R10");
    r_iir = 1; step("R10");
    step("R10");
    // re-arm via enable toggle, clear by write
    en[1] = 0; step("R3");
    en[1] = 1; step("R10");
    w_thr = 1; step("R10");
    step("R10");
    // R6 timeout: char mode ignored, FIFO reported
    tmo = 1; step("R6");
    fifo = 1; step("R6");
    step("R7");
    trig = 1; step("R5");
    rdy = 1; trig = 0; step("R5");
    // R3 everything disabled
    en = 4'h0; err = 4'hF; dlt = 4'hF; step("R3");
    step("R3");
    en = 4'h4; step("R3");
    en = 4'h8; r_lsr = 1; step("R3");
    step("R2");
    tmo = 0; rdy = 0; fifo = 0; thr = 0; en = 4'h0;
    r_msr = 1; step("R9");

    // random mix
    for (int i = 0; i < 600; i++) begin
      en   = 4'($urandom);
      if ($urandom_range(7) == 0) fifo = ~fifo;
      rdy  = ($urandom_range(3) == 0);
      trig = ($urandom_range(3) == 0);
      tmo  = ($urandom_range(3) == 0);
      if ($urandom_range(3) == 0) thr = ~thr;
      err  = ($urandom_range(5) == 0) ? 4'($urandom) : 4'h0;
      dlt  = ($urandom_range(5) == 0) ? 4'($urandom) : 4'h0;
      r_iir = ($urandom_range(3) == 0);
      r_lsr = ($urandom_range(4) == 0);
      r_msr = ($urandom_range(4) == 0);
      w_thr = ($urandom_range(5) == 0);
      step("R2");
    end
    summary();
  end
endmodule